// File: doc/BRIEF.md
# Dual-Channel Converter Serial Control Front End

This block is the digital control side of a two-channel 12-bit converter. A host sends 16-bit words over a three-wire serial link: a serial clock, a data line and an active-low frame strobe. Each word carries a 4-bit command in its top bits and a 12-bit code below it, most significant bit first. Each channel has a staging register, which the serial link writes, and an output register, which holds the code the block presents. A serial data output carries bits for daisy-chaining and returns output codes on request.

The output registers are updated from the staging registers in one of three ways. A falling edge on an active-low load strobe copies both channels. With the strobe held low, the write itself updates the output register. That happens at the sixteenth capture edge in standalone framing, or when the frame strobe rises in chained framing. An active-low clear input forces all four code registers to zero or to midscale, as configured. All pins are sampled by a fast system clock through synchronizers, so every action is taken in that clock domain.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset both codes are 0x000 and the serial output is 0. The block captures on falling serial clock edges, in standalone framing, with zero-scale clear.
- R2: Word bits [15:12] are the command and [11:0] are the code. Command 0x1 writes staging register A, 0x2 writes B and 0x3 writes both. Command 0x4 sets the configuration and 0x5 or 0x6 reads back the output code of A or B. Every other value does nothing. A staging write leaves the output codes unchanged while the load strobe is high.
- R3: Configuration bit 0 set to 1 selects rising-edge capture, and 0 selects falling-edge capture. The serial output changes only on the opposite edge while a frame is open, never on a capture edge.
- R4: In standalone framing the word is acted on at the sixteenth capture edge. Further capture edges in the same frame are ignored.
- R5: A readback command makes the next frame shift {4'b0000, output code} out on its 16 opposite edges, most significant bit first.
- R6: A falling edge on the load strobe copies both staging registers into the output registers.
- R7: While the load strobe is held low, a staging write also updates that channel's output register at the moment the word is acted on.
- R8: With configuration bit 1 set (chained framing), every capture edge shifts. The serial output gives the bit leaving the top of the 16-bit register. The last 16 bits are acted on when the frame strobe rises.
- R9: While clear is low, staging and output registers hold 0x000, or 0x800 when configuration bit 2 is 1. Clear overrides writes and loads.
- R10: In standalone framing, a frame strobe that rises before 16 capture edges discards the partial word.
- R11: A configuration write takes effect for capture edge and framing from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame strobe |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| sdo | output | 1 | Serial data out |
| code_a | output | DATA_W | Output code of channel A |
| code_b | output | DATA_W | Output code of channel B |

## Verification
The bench drives frames with both capture edges and in both framings. It samples the serial output after every serial clock edge, so a design that shifted the output on the capture edge, or lost the first readback bit to the shift, shows up as a wrong bit. Frames with too few or too many clocks target the standalone counter: a design that acted on a partial word, or kept shifting past sixteen, would corrupt channel A. A configuration frame is followed at once by a frame in the new mode, which catches a mode that switched in the middle of a frame. Clears after a midscale setting check that staging registers are cleared too, not only the outputs.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP   = 4'h0,
    CMD_WR_A  = 4'h1,
    CMD_WR_B  = 4'h2,
    CMD_WR_AB = 4'h3,
    CMD_CTRL  = 4'h4,
    CMD_RD_A  = 4'h5,
    CMD_RD_B  = 4'h6
  } cmd_e;

  typedef struct packed {
    logic clr_mid;
    logic daisy;
    logic cap_rise;
  } ctrl_t;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int N = 5,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int PW = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [PW-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {PW{RST_VAL[i]}};
      else     pipe <= {pipe[PW-2:0], din[i]};
    end
    assign lvl[i]  = pipe[PW-2];
    assign rise[i] = pipe[PW-2] & ~pipe[PW-1];
    assign fall[i] = ~pipe[PW-2] & pipe[PW-1];
  end
endmodule

// File: rtl/dac_ser_shift.sv
module dac_ser_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_act,
  input  logic               sync_rise,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               sdin_s,
  input  logic               cap_rise_cfg,
  input  logic               daisy_cfg,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] load_word,
  output logic               word_valid,
  output logic [FRAME_W-1:0] word,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic hold_bit, cap_rise_q, daisy_q;
  logic cap_ev, opp_ev, full, take;

  assign cap_ev = frame_act & (cap_rise_q ? sclk_rise : sclk_fall);
  assign opp_ev = frame_act & (cap_rise_q ? sclk_fall : sclk_rise);
  assign full   = (cnt == CNT_W'(FRAME_W));
  assign take   = cap_ev & (daisy_q | ~full);
  assign word   = sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cnt <= '0; hold_bit <= 1'b0; sdo <= 1'b0;
      word_valid <= 1'b0; cap_rise_q <= 1'b0; daisy_q <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (!frame_act) begin
        cap_rise_q <= cap_rise_cfg;
        daisy_q    <= daisy_cfg;
        cnt        <= '0;
      end
      if (sync_rise && daisy_q) word_valid <= 1'b1;
      if (load_en)   sr <= load_word;
      else if (take) sr <= {sr[FRAME_W-2:0], sdin_s};
      if (take) begin
        hold_bit <= sr[FRAME_W-1];
        if (!full) cnt <= cnt + 1'b1;
        if (!daisy_q && cnt == CNT_W'(FRAME_W - 1)) word_valid <= 1'b1;
      end
      if (opp_ev) sdo <= hold_bit;
    end
  end

  a_r4_word_at_count: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !daisy_q) |-> full);
  a_r10_partial_drop: assert property (@(posedge clk) disable iff (rst)
    (sync_rise && !daisy_q && !full) |=> !word_valid);
  a_r3_sdo_opp_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(opp_ev));
  a_r5_rb_reload: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (sr == $past(load_word)));
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_if_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      word_valid,
  input  logic [DATA_W+CMD_W-1:0]   word,
  input  logic                      clr_act,
  input  logic                      ldac_fall,
  input  logic                      ldac_low,
  output logic [DATA_W-1:0]         code_a,
  output logic [DATA_W-1:0]         code_b,
  output ctrl_t                     ctrl,
  output logic                      rb_load,
  output logic [DATA_W+CMD_W-1:0]   rb_word
);
  localparam int FRAME_W = DATA_W + CMD_W;
  localparam int NCH = 2;
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  cmd_e              cmd;
  logic [DATA_W-1:0] data, clr_val;
  logic [NCH-1:0]    wr_sel;
  logic [DATA_W-1:0] in_q  [NCH];
  logic [DATA_W-1:0] dac_q [NCH];

  assign cmd     = cmd_e'(word[FRAME_W-1 -: CMD_W]);
  assign data    = word[DATA_W-1:0];
  assign clr_val = ctrl.clr_mid ? MID : '0;

  always_comb begin
    case (cmd)
      CMD_WR_A:  wr_sel = 2'b01;
      CMD_WR_B:  wr_sel = 2'b10;
      CMD_WR_AB: wr_sel = 2'b11;
      default:   wr_sel = 2'b00;
    endcase
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[ch]  <= '0;
        dac_q[ch] <= '0;
      end else if (clr_act) begin
        in_q[ch]  <= clr_val;
        dac_q[ch] <= clr_val;
      end else begin
        if (ldac_fall) dac_q[ch] <= in_q[ch];
        if (word_valid && wr_sel[ch]) begin
          in_q[ch] <= data;
          if (ldac_low) dac_q[ch] <= data;
        end
      end
    end

    a_r9_clear_value: assert property (@(posedge clk) disable iff (rst)
      clr_act |=> (dac_q[ch] == $past(clr_val) && in_q[ch] == $past(clr_val)));
    a_r6_strobe_copy: assert property (@(posedge clk) disable iff (rst)
      (ldac_fall && !clr_act && !(word_valid && wr_sel[ch])) |=> dac_q[ch] == $past(in_q[ch]));
    a_r7_auto_update: assert property (@(posedge clk) disable iff (rst)
      (word_valid && wr_sel[ch] && ldac_low && !clr_act) |=> dac_q[ch] == $past(data));
    a_r2_code_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(dac_q[ch]) |-> $past(clr_act || ldac_fall || (word_valid && ldac_low)));
  end

  assign code_a = dac_q[0];
  assign code_b = dac_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      rb_load <= 1'b0;
      rb_word <= '0;
    end else begin
      if (word_valid && cmd == CMD_CTRL) ctrl <= ctrl_t'(data[2:0]);
      rb_load <= word_valid && (cmd == CMD_RD_A || cmd == CMD_RD_B);
      rb_word <= {{CMD_W{1'b0}}, (cmd == CMD_RD_B) ? dac_q[1] : dac_q[0]};
    end
  end
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_if_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);
  localparam int FRAME_W = DATA_W + CMD_W;
  localparam int NPIN = 5;
  localparam int IX_SDIN = 0, IX_SCLK = 1, IX_SYNC = 2, IX_LDAC = 3, IX_CLR = 4;

  logic [NPIN-1:0]    lvl, rise, fall;
  logic               word_valid, rb_load;
  logic [FRAME_W-1:0] word, rb_word;
  ctrl_t              ctrl;
  logic               unused_bits;

  dac_in_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(5'b11110)) u_sync (
    .clk(clk), .rst(rst), .din({clr_n, ldac_n, sync_n, sclk, sdin}),
    .lvl(lvl), .rise(rise), .fall(fall));

  dac_ser_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .frame_act(~lvl[IX_SYNC]), .sync_rise(rise[IX_SYNC]),
    .sclk_rise(rise[IX_SCLK]), .sclk_fall(fall[IX_SCLK]), .sdin_s(lvl[IX_SDIN]),
    .cap_rise_cfg(ctrl.cap_rise), .daisy_cfg(ctrl.daisy),
    .load_en(rb_load), .load_word(rb_word),
    .word_valid(word_valid), .word(word), .sdo(sdo));

  dac_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word(word),
    .clr_act(~lvl[IX_CLR]), .ldac_fall(fall[IX_LDAC]), .ldac_low(~lvl[IX_LDAC]),
    .code_a(code_a), .code_b(code_b), .ctrl(ctrl),
    .rb_load(rb_load), .rb_word(rb_word));

  assign unused_bits = ^{lvl[IX_SCLK], rise[IX_SDIN], fall[IX_SDIN], fall[IX_SYNC],
                         rise[IX_LDAC], rise[IX_CLR], fall[IX_CLR]};
endmodule

// File: tb/dac_serial_ctrl_test.sv
module dac_serial_ctrl_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int DW    = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [DW-1:0] code_a, code_b;

  dac_serial_ctrl uut (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .code_a(code_a), .code_b(code_b));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int kind; int req; logic [DW-1:0] val; } item_t;
  item_t q[$];
  event mon_ev;
  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference model state
  logic [15:0] msr = '0;
  logic mhold = 1'b0, msdo = 1'b0;
  logic [DW-1:0] in_m [2] = '{default: '0};
  logic [DW-1:0] dac_m [2] = '{default: '0};
  logic m_rise = 1'b0, m_daisy = 1'b0, m_mid = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin : monitor
    forever begin
      @(mon_ev);
      while (q.size() > 0) begin
        automatic item_t it = q.pop_front();
        automatic logic [DW-1:0] act =
          (it.kind == 0) ? {{(DW-1){1'b0}}, sdo} : (it.kind == 1) ? code_a : code_b;
        nchk++;
        if (act !== it.val) begin
          nerr++;
          $display("FAIL R%0d %s actual=%h expected=%h", it.req,
                   it.kind == 0 ? "sdo" : (it.kind == 1 ? "code_a" : "code_b"), act, it.val);
        end
      end
    end
  end

  task automatic push(input int kind, input int req, input logic [DW-1:0] val);
    item_t it; it.kind = kind; it.req = req; it.val = val; q.push_back(it);
  endtask
  task automatic flush(); -> mon_ev; @(negedge clk); endtask
  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic [DW-1:0] clr_code(); return m_mid ? 12'h800 : 12'h000; endfunction

  task automatic act_word(input logic [15:0] w);
    case (w[15:12])
      4'h1: begin in_m[0] = w[11:0]; if (!ldac_n) dac_m[0] = w[11:0]; end
      4'h2: begin in_m[1] = w[11:0]; if (!ldac_n) dac_m[1] = w[11:0]; end
      4'h3: begin
        in_m[0] = w[11:0]; in_m[1] = w[11:0];
        if (!ldac_n) begin dac_m[0] = w[11:0]; dac_m[1] = w[11:0]; end
      end
      4'h4: begin m_rise = w[0]; m_daisy = w[1]; m_mid = w[2]; end
      4'h5: msr = {4'h0, dac_m[0]};
      4'h6: msr = {4'h0, dac_m[1]};
      default: ;
    endcase
  endtask

  // driver: sends nbits of w (MSB first), pushes expected serial output after every edge
  task automatic send(input logic [31:0] w, input int nbits, input int tag);
    logic fr_rise, fr_daisy;
    int cnt;
    fr_rise = m_rise; fr_daisy = m_daisy; cnt = 0;
    sclk = fr_rise ? 1'b0 : 1'b1;
    wclk(HALF); sync_n = 1'b0; wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdin = w[nbits-1-i];
      wclk(HALF);
      sclk = ~sclk;                       // capture edge
      if (fr_daisy || cnt < 16) begin
        mhold = msr[15];
        msr = {msr[14:0], sdin};
        cnt++;
        if (!fr_daisy && cnt == 16) act_word(msr);
      end
      wclk(HALF);
      push(0, 3, {{(DW-1){1'b0}}, msdo});  // R3: no change on capture edge
      flush();
      sclk = ~sclk;                       // opposite edge
      msdo = mhold;
      wclk(HALF);
      push(0, tag, {{(DW-1){1'b0}}, msdo});
      flush();
    end
    sync_n = 1'b1;
    if (fr_daisy) act_word(msr);
    wclk(12);
  endtask

  task automatic check_codes(input int req);
    push(1, req, dac_m[0]); push(2, req, dac_m[1]); flush();
  endtask

  task automatic set_ldac(input logic v);
    if (ldac_n && !v) begin dac_m[0] = in_m[0]; dac_m[1] = in_m[1]; end
    ldac_n = v; wclk(6);
  endtask

  task automatic ldac_pulse(); set_ldac(1'b0); set_ldac(1'b1); endtask

  task automatic clear_pulse();
    clr_n = 1'b0; wclk(6); clr_n = 1'b1; wclk(6);
    in_m[0] = clr_code(); in_m[1] = clr_code();
    dac_m[0] = clr_code(); dac_m[1] = clr_code();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : driver
    wclk(5); rst = 1'b0; wclk(5);
    // R1: reset state
    push(0, 1, '0); check_codes(1);
    // R2: staging writes leave outputs alone while strobe high
    send(32'h1123, 16, 3); send(32'h2ABC, 16, 3); check_codes(2);
    // R6: strobe falling edge copies both channels
    ldac_pulse(); check_codes(6);
    // R5: readback of A then B, shifted out on the following frame
    send(32'h5000, 16, 3); send(32'h0000, 16, 5);
    send(32'h6000, 16, 3); send(32'h0000, 16, 5);
    // R10: partial standalone frame discarded
    send(32'h1F, 8, 3); ldac_pulse(); check_codes(10);
    // R4: clocks past sixteen ignored
    send(32'h0013_210F, 24, 3); ldac_pulse(); check_codes(4);
    // R7: auto update with strobe held low
    set_ldac(1'b0); send(32'h3555, 16, 3); check_codes(7); set_ldac(1'b1);
    // R9: clear to zero, then to midscale including staging registers
    clear_pulse(); check_codes(9);
    send(32'h4004, 16, 3); clear_pulse(); check_codes(9);
    ldac_pulse(); check_codes(9);
    // R3 and R11: rising-edge capture from the frame after the setting
    send(32'h4005, 16, 3); send(32'h1777, 16, 3); ldac_pulse(); check_codes(3);
    send(32'h5000, 16, 3); send(32'h0000, 16, 5);
    // R8: chained framing, longer frame, last sixteen bits count
    send(32'h4007, 16, 3); send(32'h000A_12AB, 20, 8); ldac_pulse(); check_codes(8);
    set_ldac(1'b0); send(32'h2456, 16, 8); check_codes(8); set_ldac(1'b1);
    // R11: back to falling capture while chained
    send(32'h4002, 16, 8); send(32'h1BCD, 16, 8); ldac_pulse(); check_codes(11);
    send(32'h6000, 16, 8); send(32'h0000, 16, 5);
    // return to standalone framing, zero clear
    send(32'h4000, 16, 8); send(32'h2321, 16, 3); ldac_pulse(); check_codes(2);
    clear_pulse(); check_codes(9);
    wclk(4); flush();
    done = 1;
    summary();
    $finish;
  end
endmodule